// File: doc/BRIEF.md
# Multi-Channel DMA Interrupt Mask Unit

This block gathers completion events from the transmit and receive channel engines of a small DMA engine. It also takes one DMA-level host-error event. It turns them into a single host interrupt line. There are three banks: transmit, receive and DMA-level. Each bank keeps a raw pending word, an enable mask, and a masked view that is the raw word ANDed with the mask. A channel's bit position in every word is its channel number.

Software reaches the banks through a simple register port. Mask bits are changed through separate set-strobe and clear-strobe addresses, so changing one enable never needs a read-modify-write. Writing a one to a bank's raw address acknowledges that channel's completion and clears its pending bit. The interrupt line is a one-cycle pulse. After each pulse the line is disarmed. A write to the end-of-interrupt address arms it again, and if anything enabled is still pending the line pulses again on the next cycle.

Top module: `imask_top`

## Requirements
- R1: After reset every raw word and every mask reads zero, `irq` is low and the line is armed.
- R2: A one-cycle pulse on an event input sets the raw bit at the channel's position on the next clock edge. The bit stays set whatever the mask holds, until it is acknowledged.
- R3: Writing to a mask-set address (bank base + 0x8) sets each mask bit written as one and leaves bits written as zero unchanged. Reading the mask-set or mask-clear address returns the current mask.
- R4: Writing to a mask-clear address (bank base + 0xC) clears each mask bit written as one. Writing all ones disables every channel of that bank at once.
- R5: Reading the masked address (bank base + 0x4) returns raw AND mask. Reading the raw address (bank base + 0x0) returns the raw word.
- R6: Writing to the raw address clears each raw bit written as one. An event arriving on the same edge as an acknowledge of the same bit wins, and the bit stays set.
- R7: `irq` is high exactly when the line is armed and at least one masked bit is set. On the edge after `irq` is seen high the line disarms, so `irq` lasts one cycle.
- R8: Any write to the end-of-interrupt address 0x94 re-arms the line. If a masked bit is still pending, `irq` is high in the cycle right after that write.
- R9: Bank bases are 0x80 for transmit, 0xA0 for receive and 0xB0 for the DMA-level bank. The host error is bit 1 of the DMA-level bank, and its bit 0 always reads zero. Bits at or above a bank's channel count read zero and cannot be set.
- R10: Addresses outside the map, and addresses with nonzero low two bits, read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEvt | input | NUM_TX | Transmit channel completion pulses |
| rxEvt | input | NUM_RX | Receive channel completion pulses |
| hostErrEvt | input | 1 | DMA-level host error pulse |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address, used for reads and writes |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irq | output | 1 | Host interrupt pulse |

## Verification
The bench builds the block with eight transmit channels and four receive channels. Because the receive bank is narrower than the data word, an all-ones mask write shows that the bits above the channel count stay zero. The two-bit DMA-level bank shows that only the host-error position can ever be set. The interrupt sequence is driven through its disarm, quiet, end-of-interrupt and re-pulse steps. An event and an acknowledge of the same bit are applied on the same edge.

// File: rtl/imask_pkg.sv
package imask_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NUM_BANKS = 3;

  // bank selector from address bits [7:4]
  localparam logic [3:0] TX_PAGE  = 4'h8;
  localparam logic [3:0] RX_PAGE  = 4'hA;
  localparam logic [3:0] DMA_PAGE = 4'hB;
  localparam logic [ADDR_W-1:0] EOI_ADDR = 8'h94;
  localparam int HOST_ERR_BIT = 1;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_RAW    = 2'd1,
    RD_MASKED = 2'd2,
    RD_MASK   = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] setMask;
    logic [NUM_BANKS-1:0] clrMask;
    logic [NUM_BANKS-1:0] ack;
    logic                 eoi;
    logic [1:0]           rdBank;
    rdKind_e              rdKind;
  } ctlStrb_t;

endpackage

// File: rtl/imask_bank.sv
module imask_bank #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] evt,
  input  logic              setStb,
  input  logic              clrStb,
  input  logic              ackStb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] mask
);

  logic [DATA_W-1:0] rawNext;
  logic [DATA_W-1:0] maskNext;

  always_comb begin
    rawNext = raw;
    if (ackStb) rawNext = rawNext & ~wdata;
    rawNext = (rawNext | evt) & VALID;
    maskNext = mask;
    if (setStb) maskNext = maskNext | wdata;
    if (clrStb) maskNext = maskNext & ~wdata;
    maskNext = maskNext & VALID;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw  <= rawNext;
      mask <= maskNext;
    end
  end

  // R2
  evt_sets_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(evt & VALID)) |=> ((raw & $past(evt & VALID)) == $past(evt & VALID)));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    setStb |=> ((mask & $past(wdata & VALID)) == $past(wdata & VALID)));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrStb && !setStb) |=> ((mask & $past(wdata)) == '0));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |=> ((raw & $past(wdata & ~evt)) == '0));

endmodule

// File: rtl/imask_ctrl.sv
module imask_ctrl
  import imask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              anyPend,
  output ctlStrb_t          strb,
  output logic              irq
);

  logic       bankHit;
  logic [1:0] bankIdx;
  logic       armed;

  always_comb begin
    bankHit = 1'b1;
    bankIdx = 2'd0;
    case (regAddr[7:4])
      TX_PAGE:  bankIdx = 2'd0;
      RX_PAGE:  bankIdx = 2'd1;
      DMA_PAGE: bankIdx = 2'd2;
      default:  bankHit = 1'b0;
    endcase
    if (regAddr[1:0] != 2'b00) bankHit = 1'b0;

    strb = '0;
    strb.rdBank = bankIdx;
    strb.rdKind = RD_NONE;
    if (bankHit) begin
      case (regAddr[3:2])
        2'd0: begin
          strb.rdKind = RD_RAW;
          strb.ack[bankIdx] = regWr;
        end
        2'd1: strb.rdKind = RD_MASKED;
        2'd2: begin
          strb.rdKind = RD_MASK;
          strb.setMask[bankIdx] = regWr;
        end
        default: begin
          strb.rdKind = RD_MASK;
          strb.clrMask[bankIdx] = regWr;
        end
      endcase
    end
    strb.eoi = regWr && (regAddr == EOI_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         armed <= 1'b1;
    else if (strb.eoi) armed <= 1'b1;
    else if (irq)      armed <= 1'b0;
  end

  assign irq = armed & anyPend;

  // R7
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !strb.eoi) |=> !irq);

  // R8
  eoi_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && anyPend) |=> irq);

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setMask, strb.clrMask, strb.ack, strb.eoi}));

endmodule

// File: rtl/imask_dp.sv
module imask_dp
  import imask_pkg::*;
#(
  parameter int NUM_TX = 8,
  parameter int NUM_RX = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [NUM_TX-1:0] txEvt,
  input  logic [NUM_RX-1:0] rxEvt,
  input  logic              hostErrEvt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              anyPend
);

  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] TX_VALID  = ONES >> (DATA_W - NUM_TX);
  localparam logic [DATA_W-1:0] RX_VALID  = ONES >> (DATA_W - NUM_RX);
  localparam logic [DATA_W-1:0] DMA_VALID = DATA_W'(1) << HOST_ERR_BIT;
  localparam logic [NUM_BANKS-1:0][DATA_W-1:0] BANK_VALID =
    {DMA_VALID, RX_VALID, TX_VALID};

  logic [NUM_BANKS-1:0][DATA_W-1:0] evtAll;
  logic [NUM_BANKS-1:0][DATA_W-1:0] rawAll;
  logic [NUM_BANKS-1:0][DATA_W-1:0] maskAll;
  logic [NUM_BANKS-1:0]             bankPend;

  always_comb begin
    evtAll    = '0;
    evtAll[0] = DATA_W'(txEvt);
    evtAll[1] = DATA_W'(rxEvt);
    evtAll[2][HOST_ERR_BIT] = hostErrEvt;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    imask_bank #(
      .DATA_W (DATA_W),
      .VALID  (BANK_VALID[b])
    ) bank_i (
      .clk    (clk),
      .rstN   (rstN),
      .evt    (evtAll[b]),
      .setStb (strb.setMask[b]),
      .clrStb (strb.clrMask[b]),
      .ackStb (strb.ack[b]),
      .wdata  (wdata),
      .raw    (rawAll[b]),
      .mask   (maskAll[b])
    );
    assign bankPend[b] = |(rawAll[b] & maskAll[b]);
  end

  assign anyPend = |bankPend;

  always_comb begin
    rdata = '0;
    if (strb.rdBank < 2'(NUM_BANKS)) begin
      case (strb.rdKind)
        RD_RAW:    rdata = rawAll[strb.rdBank];
        RD_MASKED: rdata = rawAll[strb.rdBank] & maskAll[strb.rdBank];
        RD_MASK:   rdata = maskAll[strb.rdBank];
        default:   rdata = '0;
      endcase
    end
  end

  // R9
  dma_bit0_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawAll[2][0] == 1'b0) && (maskAll[2][0] == 1'b0));

endmodule

// File: rtl/imask_top.sv
module imask_top
  import imask_pkg::*;
#(
  parameter int NUM_TX = 8,
  parameter int NUM_RX = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_TX-1:0] txEvt,
  input  logic [NUM_RX-1:0] rxEvt,
  input  logic              hostErrEvt,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);

  ctlStrb_t strb;
  logic     anyPend;

  imask_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regAddr (regAddr),
    .anyPend (anyPend),
    .strb    (strb),
    .irq     (irq)
  );

  imask_dp #(
    .NUM_TX (NUM_TX),
    .NUM_RX (NUM_RX)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .txEvt      (txEvt),
    .rxEvt      (rxEvt),
    .hostErrEvt (hostErrEvt),
    .wdata      (regWdata),
    .rdata      (regRdata),
    .anyPend    (anyPend)
  );

endmodule

// File: tb/imask_top_tb_top.sv
module imask_top_tb_top;

  localparam int NTX = 8;
  localparam int NRX = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NTX-1:0] txEvt = '0;
  logic [NRX-1:0] rxEvt = '0;
  logic           hostErrEvt = 1'b0;
  logic           regWr = 1'b0;
  logic [7:0]     regAddr = '0;
  logic [31:0]    regWdata = '0;
  logic [31:0]    regRdata;
  logic           irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  imask_top #(.NUM_TX(NTX), .NUM_RX(NRX)) dut_i (
    .clk(clk), .rstN(rstN), .txEvt(txEvt), .rxEvt(rxEvt),
    .hostErrEvt(hostErrEvt), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pulseTx(input int ch);
    @(negedge clk);
    txEvt = NTX'(1) << ch;
    @(negedge clk);
    txEvt = '0;
  endtask

  task automatic cleanup();
    for (int b = 0; b < 3; b++) begin
      logic [7:0] base;
      base = (b == 0) ? 8'h80 : (b == 1) ? 8'hA0 : 8'hB0;
      wr(base + 8'h0C, 32'hFFFF_FFFF);
      wr(base, 32'hFFFF_FFFF);
    end
    wr(8'h94, 32'h0);
  endtask

  task automatic tReset();
    logic [31:0] v;
    check("R1 irq after reset", 32'(irq), 32'h0);
    rd(8'h80, v); check("R1 tx raw", v, 32'h0);
    rd(8'h88, v); check("R1 tx mask", v, 32'h0);
    rd(8'hA8, v); check("R1 rx mask", v, 32'h0);
    rd(8'hB0, v); check("R1 dma raw", v, 32'h0);
  endtask

  task automatic tRawMask();
    logic [31:0] v;
    cleanup();
    pulseTx(5);
    check("R7 no irq while masked off", 32'(irq), 32'h0);
    rd(8'h80, v); check("R2 raw set at bit 5", v, 32'h20);
    rd(8'h84, v); check("R5 masked zero", v, 32'h0);
    wr(8'h88, 32'h20);
    check("R7 irq on enable", 32'(irq), 32'h1);
    rd(8'h84, v); check("R5 masked after enable", v, 32'h20);
    check("R7 irq one cycle", 32'(irq), 32'h0);
    rd(8'h80, v); check("R2 raw held", v, 32'h20);
  endtask

  task automatic tSetClr();
    logic [31:0] v;
    cleanup();
    wr(8'h88, 32'h05);
    rd(8'h88, v); check("R3 set read", v, 32'h05);
    rd(8'h8C, v); check("R3 clr addr reads mask", v, 32'h05);
    wr(8'h88, 32'h02);
    rd(8'h88, v); check("R3 set keeps others", v, 32'h07);
    wr(8'h8C, 32'h04);
    rd(8'h88, v); check("R4 clr one bit", v, 32'h03);
    wr(8'h8C, 32'h0);
    rd(8'h88, v); check("R4 zero no effect", v, 32'h03);
    wr(8'h8C, 32'hFFFF_FFFF);
    rd(8'h88, v); check("R4 clr all", v, 32'h0);
    wr(8'hA8, 32'hFFFF_FFFF);
    rd(8'hA8, v); check("R9 rx width limit", v, 32'h0F);
    wr(8'hAC, 32'hFFFF_FFFF);
    rd(8'hA8, v); check("R4 rx clr all", v, 32'h0);
  endtask

  task automatic tAck();
    logic [31:0] v;
    cleanup();
    pulseTx(3);
    pulseTx(1);
    rd(8'h80, v); check("R2 two raw bits", v, 32'h0A);
    wr(8'h80, 32'h08);
    rd(8'h80, v); check("R6 ack clears bit 3", v, 32'h02);
    @(negedge clk);
    txEvt = 8'h02; regWr = 1'b1; regAddr = 8'h80; regWdata = 32'h02;
    @(negedge clk);
    txEvt = '0; regWr = 1'b0;
    rd(8'h80, v); check("R6 event beats ack", v, 32'h02);
  endtask

  task automatic tEoi();
    logic [31:0] v;
    cleanup();
    wr(8'hA8, 32'h04);
    @(negedge clk);
    rxEvt = 4'h4;
    @(negedge clk);
    rxEvt = '0;
    check("R7 rx irq", 32'(irq), 32'h1);
    @(negedge clk);
    check("R7 disarmed", 32'(irq), 32'h0);
    repeat (3) @(negedge clk);
    check("R7 stays low", 32'(irq), 32'h0);
    wr(8'h94, 32'h0);
    check("R8 re-pulse after eoi", 32'(irq), 32'h1);
    @(negedge clk);
    check("R8 re-pulse one cycle", 32'(irq), 32'h0);
    wr(8'hA0, 32'h04);
    wr(8'h94, 32'h0);
    check("R8 no pulse when clear", 32'(irq), 32'h0);
    rd(8'hA0, v); check("R6 rx acked", v, 32'h0);
  endtask

  task automatic tHostErr();
    logic [31:0] v;
    cleanup();
    @(negedge clk);
    hostErrEvt = 1'b1;
    @(negedge clk);
    hostErrEvt = 1'b0;
    rd(8'hB0, v); check("R9 host err bit 1", v, 32'h2);
    rd(8'hB4, v); check("R5 dma masked off", v, 32'h0);
    wr(8'hB8, 32'hFFFF_FFFF);
    check("R7 host err irq", 32'(irq), 32'h1);
    rd(8'hB8, v); check("R9 dma mask only bit 1", v, 32'h2);
  endtask

  task automatic tUnmapped();
    logic [31:0] v;
    cleanup();
    wr(8'h89, 32'hFF);
    wr(8'hC8, 32'hFF);
    wr(8'h90, 32'hFF);
    rd(8'h88, v); check("R10 misaligned write ignored", v, 32'h0);
    rd(8'hC8, v); check("R10 unmapped read zero", v, 32'h0);
    rd(8'h94, v); check("R10 eoi reads zero", v, 32'h0);
    rd(8'hA8, v); check("R10 rx mask untouched", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRawMask();
    tSetClr();
    tAck();
    tEoi();
    tHostErr();
    tUnmapped();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule